// File: doc/BRIEF.md
# Three-format instruction decoder

This block turns one 32-bit instruction word into the control fields that an execute stage needs. These fields are the action to take, the ALU operation, the kind and index of each source operand, the 16-bit immediate, the destination register index and which part of that register is written. The top three bits of the word pick the instruction class. Each class lays out its opcode and operands differently.

The decode logic is combinational. Its result is captured in an output register on every cycle where the decode strobe is high. When the word is not a legal instruction, the register keeps its previous fields and raises an illegal flag. That flag stays up until the next legal decode. For the jump class, the block only reports the action. A separate unit extracts the jump target and condition.

Top module: `instr_decoder`

## Requirements
- R1: While reset is low, and after it is released until the first strobe, all outputs are zero. An action of zero means "none", and `illegal_o` is 0.
- R2: Bits [31:29] select the class: 0 is jump, 1 is ALU register-register and 2 is immediate move. The values 3 to 7 are illegal.
- R3: In the ALU class, bits [28:16] are the opcode, bits [15:8] are the first register index and bits [7:0] are the second. Both sources are reported as register kind (0), and the immediate is 0.
- R4: ALU opcodes 0, 1, 2, 3 and 4 give `alu_op_o` 0 (add), 1 (subtract), 2 (shift left), 3 (shift right) and 4 (compare), with action 1. Any other ALU opcode is illegal.
- R5: Add, subtract and compare write the register named in bits [7:0]. Both shifts write the register named in bits [15:8]. An ALU destination is always written in full (`dst_half_o` = 0).
- R6: In the move class, bits [28:24] are the opcode, bits [23:16] are the destination index and bits [15:0] are the immediate. The result has action 2 and a first source of immediate kind (1). Both source indices and the second source kind are 0. Opcode 0 writes the low half (`dst_half_o` = 1), opcode 1 writes the high half (2), and any other opcode is illegal.
- R7: A jump-class word gives action 3 and `illegal_o` 0. All other fields are zero, whatever bits [28:0] hold.
- R8: An illegal word sets `illegal_o` to 1 and leaves every other output unchanged. A later legal decode clears the flag.
- R9: When the strobe is low, no output changes, whatever the instruction input holds.
- R10: `alu_op_o` is 0 after every legal decode that is not in the ALU class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode strobe; the word is captured on the rising edge |
| instr_i | input | 32 | Instruction word |
| action_o | output | 2 | 0 none, 1 ALU, 2 move, 3 jump |
| alu_op_o | output | 3 | ALU operation code |
| src1_kind_o | output | 1 | First source: 0 register, 1 immediate |
| src1_idx_o | output | 8 | First source register index |
| src2_kind_o | output | 1 | Second source: 0 register, 1 immediate |
| src2_idx_o | output | 8 | Second source register index |
| imm_o | output | 16 | Immediate operand |
| dst_idx_o | output | 8 | Destination register index |
| dst_half_o | output | 2 | 0 full word, 1 low half, 2 high half |
| illegal_o | output | 1 | Last strobed word was illegal |

## Verification
The properties assume that `dec_valid_i` is a clean level that is sampled only at rising edges. They also assume that `instr_i` only matters on strobed cycles, so they never tie a registered field to the input except through a strobe one cycle earlier. The stimulus changes inputs only on falling edges. It mixes strobed and unstrobed cycles and drives arbitrary words while the strobe is low. Random words are drawn across all eight classes, so illegal classes, illegal opcodes and legal decodes follow each other in every order.

// File: rtl/instr_dec_pkg.sv
package instr_dec_pkg;
  localparam int unsigned INSTR_W    = 32;
  localparam int unsigned CLASS_W    = 3;
  localparam int unsigned IDX_W      = 8;
  localparam int unsigned IMM_W      = 16;
  localparam int unsigned ALU_OPC_W  = INSTR_W - CLASS_W - 2 * IDX_W;
  localparam int unsigned MOV_OPC_W  = INSTR_W - CLASS_W - IDX_W - IMM_W;
  localparam int unsigned BODY_W     = INSTR_W - CLASS_W;

  typedef enum logic [1:0] {ACT_NONE, ACT_ALU, ACT_MOVE, ACT_JUMP} action_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_SHL, ALU_SHR, ALU_CMP} alu_op_e;
  typedef enum logic       {SRC_REG, SRC_IMM} src_kind_e;
  typedef enum logic [1:0] {WR_FULL, WR_LOW, WR_HIGH} wr_half_e;
  typedef enum logic [CLASS_W-1:0] {
    CLS_JUMP = 3'd0, CLS_ALU = 3'd1, CLS_MOVE = 3'd2
  } instr_class_e;

  typedef struct packed {
    action_e              action;
    alu_op_e              alu_op;
    src_kind_e            src1_kind;
    logic [IDX_W-1:0]     src1_idx;
    src_kind_e            src2_kind;
    logic [IDX_W-1:0]     src2_idx;
    logic [IMM_W-1:0]     imm;
    logic [IDX_W-1:0]     dst_idx;
    wr_half_e             dst_half;
  } dec_fields_t;
endpackage

// File: rtl/alu_fmt_dec.sv
module alu_fmt_dec
  import instr_dec_pkg::*;
(
  input  logic [BODY_W-1:0] body_i,
  output dec_fields_t       fields_o,
  output logic              legal_o
);
  logic [ALU_OPC_W-1:0] opc;
  logic [IDX_W-1:0]     ra, rb;

  assign opc = body_i[BODY_W-1 -: ALU_OPC_W];
  assign ra  = body_i[2*IDX_W-1 -: IDX_W];
  assign rb  = body_i[IDX_W-1:0];

  always_comb begin
    fields_o           = '0;
    fields_o.action    = ACT_ALU;
    fields_o.src1_kind = SRC_REG;
    fields_o.src1_idx  = ra;
    fields_o.src2_kind = SRC_REG;
    fields_o.src2_idx  = rb;
    fields_o.dst_half  = WR_FULL;
    legal_o            = 1'b1;
    case (opc)
      ALU_OPC_W'(0): begin fields_o.alu_op = ALU_ADD; fields_o.dst_idx = rb; end
      ALU_OPC_W'(1): begin fields_o.alu_op = ALU_SUB; fields_o.dst_idx = rb; end
      ALU_OPC_W'(2): begin fields_o.alu_op = ALU_SHL; fields_o.dst_idx = ra; end
      ALU_OPC_W'(3): begin fields_o.alu_op = ALU_SHR; fields_o.dst_idx = ra; end
      ALU_OPC_W'(4): begin fields_o.alu_op = ALU_CMP; fields_o.dst_idx = rb; end
      default:       legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mov_fmt_dec.sv
module mov_fmt_dec
  import instr_dec_pkg::*;
(
  input  logic [BODY_W-1:0] body_i,
  output dec_fields_t       fields_o,
  output logic              legal_o
);
  logic [MOV_OPC_W-1:0] opc;

  assign opc = body_i[BODY_W-1 -: MOV_OPC_W];

  always_comb begin
    fields_o           = '0;
    fields_o.action    = ACT_MOVE;
    fields_o.src1_kind = SRC_IMM;
    fields_o.imm       = body_i[IMM_W-1:0];
    fields_o.dst_idx   = body_i[IMM_W+IDX_W-1 -: IDX_W];
    legal_o            = 1'b1;
    case (opc)
      MOV_OPC_W'(0): fields_o.dst_half = WR_LOW;
      MOV_OPC_W'(1): fields_o.dst_half = WR_HIGH;
      default:       legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_dec_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 dec_valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  output logic [1:0]           action_o,
  output logic [2:0]           alu_op_o,
  output logic                 src1_kind_o,
  output logic [IDX_W-1:0]     src1_idx_o,
  output logic                 src2_kind_o,
  output logic [IDX_W-1:0]     src2_idx_o,
  output logic [IMM_W-1:0]     imm_o,
  output logic [IDX_W-1:0]     dst_idx_o,
  output logic [1:0]           dst_half_o,
  output logic                 illegal_o
);
  logic [CLASS_W-1:0] cls;
  logic [BODY_W-1:0]  body;
  dec_fields_t        alu_f, mov_f, jmp_f, nxt_f, q_f;
  logic               alu_ok, mov_ok, nxt_ok, ill_q;

  assign cls  = instr_i[INSTR_W-1 -: CLASS_W];
  assign body = instr_i[BODY_W-1:0];

  alu_fmt_dec u_alu (.body_i(body), .fields_o(alu_f), .legal_o(alu_ok));
  mov_fmt_dec u_mov (.body_i(body), .fields_o(mov_f), .legal_o(mov_ok));

  // jump operands are decoded elsewhere; only the class is reported
  always_comb begin
    jmp_f        = '0;
    jmp_f.action = ACT_JUMP;
  end

  always_comb begin
    nxt_f  = '0;
    nxt_ok = 1'b0;
    case (cls)
      CLS_JUMP: begin nxt_f = jmp_f; nxt_ok = 1'b1;   end
      CLS_ALU:  begin nxt_f = alu_f; nxt_ok = alu_ok; end
      CLS_MOVE: begin nxt_f = mov_f; nxt_ok = mov_ok; end
      default:  nxt_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_f   <= '0;
      ill_q <= 1'b0;
    end else if (dec_valid_i) begin
      ill_q <= !nxt_ok;
      if (nxt_ok) q_f <= nxt_f;
    end
  end

  assign action_o    = q_f.action;
  assign alu_op_o    = q_f.alu_op;
  assign src1_kind_o = q_f.src1_kind;
  assign src1_idx_o  = q_f.src1_idx;
  assign src2_kind_o = q_f.src2_kind;
  assign src2_idx_o  = q_f.src2_idx;
  assign imm_o       = q_f.imm;
  assign dst_idx_o   = q_f.dst_idx;
  assign dst_half_o  = q_f.dst_half;
  assign illegal_o   = ill_q;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk
  import instr_dec_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 dec_valid_i,
  input logic [INSTR_W-1:0]   instr_i,
  input logic [1:0]           action_o,
  input logic [2:0]           alu_op_o,
  input logic                 src1_kind_o,
  input logic [IDX_W-1:0]     src1_idx_o,
  input logic                 src2_kind_o,
  input logic [IDX_W-1:0]     src2_idx_o,
  input logic [IMM_W-1:0]     imm_o,
  input logic [IDX_W-1:0]     dst_idx_o,
  input logic [1:0]           dst_half_o,
  input logic                 illegal_o
);
  logic [63:0] all_o;
  assign all_o = {action_o, alu_op_o, src1_kind_o, src1_idx_o, src2_kind_o,
                  src2_idx_o, imm_o, dst_idx_o, dst_half_o, illegal_o};

  p_bad_class_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i && (instr_i[31:29] > 3'd2) |=> illegal_o);

  p_alu_fields_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o == 2'd1 |-> src1_kind_o == 1'b0 && src2_kind_o == 1'b0 && imm_o == '0);

  p_alu_op_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o == 2'd1 |-> alu_op_o <= 3'd4);

  p_alu_dst_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o == 2'd1 |-> dst_half_o == 2'd0 &&
      (((alu_op_o == 3'd2 || alu_op_o == 3'd3) && dst_idx_o == src1_idx_o) ||
       (!(alu_op_o == 3'd2 || alu_op_o == 3'd3) && dst_idx_o == src2_idx_o)));

  p_move_fields_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o == 2'd2 |-> src1_kind_o == 1'b1 && (dst_half_o == 2'd1 || dst_half_o == 2'd2));

  p_jump_class_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i && instr_i[31:29] == 3'd0 |=> action_o == 2'd3 && !illegal_o);

  p_illegal_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(illegal_o) |-> $stable(all_o[63:1]));

  p_no_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |=> $stable(all_o));

  p_alu_op_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    action_o != 2'd1 |-> alu_op_o == 3'd0);
endmodule

bind instr_decoder instr_decoder_chk u_chk (.*);

// File: tb/tb_instr_decoder.sv
module tb_instr_decoder;
  localparam time CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dec_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [1:0]  action_o, dst_half_o;
  logic [2:0]  alu_op_o;
  logic        src1_kind_o, src2_kind_o, illegal_o;
  logic [7:0]  src1_idx_o, src2_idx_o, dst_idx_o;
  logic [15:0] imm_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int e_act, e_alu, e_k1, e_i1, e_k2, e_i2, e_imm, e_dst, e_half, e_ill;

  instr_decoder dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input string name, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, name, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "action",    int'(action_o),    e_act);
    chk(tag, "alu_op",    int'(alu_op_o),    e_alu);
    chk(tag, "src1_kind", int'(src1_kind_o), e_k1);
    chk(tag, "src1_idx",  int'(src1_idx_o),  e_i1);
    chk(tag, "src2_kind", int'(src2_kind_o), e_k2);
    chk(tag, "src2_idx",  int'(src2_idx_o),  e_i2);
    chk(tag, "imm",       int'(imm_o),       e_imm);
    chk(tag, "dst_idx",   int'(dst_idx_o),   e_dst);
    chk(tag, "dst_half",  int'(dst_half_o),  e_half);
    chk(tag, "illegal",   int'(illegal_o),   e_ill);
  endtask

  task automatic model_clear();
    e_act = 0; e_alu = 0; e_k1 = 0; e_i1 = 0; e_k2 = 0; e_i2 = 0;
    e_imm = 0; e_dst = 0; e_half = 0; e_ill = 0;
  endtask

  // behavioural model of one strobed decode, taken from the requirements
  task automatic model_decode(input logic [31:0] w);
    int cls, opc;
    cls = int'(w >> 29);
    if (cls == 0) begin
      model_clear(); e_act = 3;
    end else if (cls == 1) begin
      opc = int'((w >> 16) & 32'h1FFF);
      if (opc <= 4) begin
        model_clear();
        e_act = 1; e_alu = opc;
        e_i1 = int'((w >> 8) & 32'hFF); e_i2 = int'(w & 32'hFF);
        e_dst = (opc == 2 || opc == 3) ? e_i1 : e_i2;
      end else e_ill = 1;
    end else if (cls == 2) begin
      opc = int'((w >> 24) & 32'h1F);
      if (opc <= 1) begin
        model_clear();
        e_act = 2; e_k1 = 1;
        e_imm = int'(w & 32'hFFFF); e_dst = int'((w >> 16) & 32'hFF);
        e_half = opc + 1;
      end else e_ill = 1;
    end else e_ill = 1;
  endtask

  task automatic step(input logic v, input logic [31:0] w, input string tag);
    @(negedge clk_i);
    dec_valid_i = v;
    instr_i = w;
    @(posedge clk_i);
    if (v) model_decode(w);
    #1;
    compare_all(tag);
  endtask

  function automatic logic [31:0] alu_w(input int opc, input int a, input int b);
    return {3'd1, 13'(opc), 8'(a), 8'(b)};
  endfunction

  function automatic logic [31:0] mov_w(input int opc, input int r, input int imm);
    return {3'd2, 5'(opc), 8'(r), 16'(imm)};
  endfunction

  initial begin
    model_clear();
    #(CLK_PERIOD * 2 + 1);
    compare_all("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 32'hFFFF_FFFF, "R1");

    step(1'b1, alu_w(0, 8'h12, 8'h34), "R4");   // add
    step(1'b1, alu_w(1, 8'hA5, 8'h5A), "R5");   // sub
    step(1'b1, alu_w(2, 8'h07, 8'hF0), "R5");   // shl -> dst = first
    step(1'b1, alu_w(3, 8'hFF, 8'h01), "R5");   // shr
    step(1'b1, alu_w(4, 8'h03, 8'h09), "R3");   // cmp
    step(1'b1, alu_w(5, 8'h11, 8'h22), "R4");   // illegal opcode, hold
    step(1'b1, alu_w(13'h1FFF, 1, 2), "R8");
    step(1'b1, mov_w(0, 8'h05, 16'hBEEF), "R6");
    step(1'b1, mov_w(1, 8'hC3, 16'h8000), "R10");
    step(1'b1, mov_w(2, 8'h01, 16'h1234), "R6");
    step(1'b1, mov_w(31, 8'h02, 16'hFFFF), "R8");
    step(1'b0, alu_w(0, 1, 1), "R9");
    step(1'b0, 32'h0000_0000, "R9");
    step(1'b1, 32'h1FFF_FFFF, "R7");            // jump with all body bits set
    step(1'b1, 32'h0A00_0000, "R7");
    for (int c = 3; c < 8; c++) step(1'b1, {3'(c), 29'h155_5555}, "R2");
    step(1'b1, alu_w(2, 8'h44, 8'h55), "R8");   // legal clears flag
    step(1'b0, 32'hE000_0000, "R9");
    step(1'b1, 32'h0000_0000, "R10");

    for (int i = 0; i < 600; i++) begin
      logic [31:0] w;
      logic v;
      w = $urandom;
      if ((i % 3) == 0) w[28:16] = 13'($urandom_range(0, 6));
      if ((i % 5) == 1) w[28:24] = 5'($urandom_range(0, 3));
      v = ($urandom_range(0, 3) != 0);
      step(v, w, "R2");
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule